// File: doc/BRIEF.md
# Video sync and raster interrupt generator

This block sits between a display timing controller and the monitor and CPU. It watches the horizontal and vertical sync pulses. From them it makes a shaped monitor sync output and a periodic, active-low CPU interrupt.

Inside each horizontal sync pulse, a small phase counter steps on a character-clock enable. It opens a sync window a fixed number of character periods after the pulse begins, and closes it a fixed number of periods later. The counter then stays locked until horizontal sync goes low again. A line counter counts horizontal pulses since the last vertical sync. While it is below four, the sync output is inverted. This marks the first four lines of each frame.

A 6-bit interrupt counter advances at the end of every horizontal pulse. It raises an interrupt once every 52 lines. When the line counter drops from four or more back below four, which happens at vertical sync, the interrupt counter is cleared so that its phase follows the frame. An acknowledge input clears both the counter and the pending interrupt.

The whole block runs on one system clock. The character clock enters as a one-cycle enable strobe.

Top module: `sync_irq_gen`

## Requirements
- R1: After reset, monSync is 0 and irqN is 1. The line counter rests at its stop value of 28, so no inversion applies before the first vertical sync.
- R2: While hSyncIn is high, the window is active from the 4th through the 7th clock edge at which chrEn is sampled high; during the window monSync is the inverse of its idle level. From the 8th such edge on, monSync stays at its idle level until hSyncIn goes low.
- R3: While hSyncIn is low, the phase counter is held cleared, and monSync equals its idle level: 1 on inverted lines, 0 otherwise.
- R4: The line counter advances on the clock edge where hSyncIn is sampled low after being sampled high (end of a pulse). A rising edge of vSyncIn clears it to 0, and it holds at 28 instead of wrapping.
- R5: The sync output is inverted while the line count is below 4. These are exactly the first four horizontal pulses after vertical sync. Later pulses are not inverted, including pulses more than 32 lines after vertical sync.
- R6: When the line count falls from 4 or more to below 4, the interrupt counter is cleared on the next clock. The next interrupt then comes on the 52nd pulse end after that vertical sync.
- R7: The 6-bit interrupt counter advances at each pulse end. At the pulse end where it holds 51, it wraps to 0 and sets the interrupt, and irqN goes low. This gives one interrupt per 52 lines.
- R8: irqAck high for one clock clears the interrupt counter and the pending interrupt, so irqN is 1 on the next clock. If the acknowledge coincides with a wrap, the acknowledge wins and no interrupt is raised.
- R9: monSync changes only at a clock where chrEn is high while hSyncIn is high, at the end of a pulse, or at a vertical sync rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hSyncIn | input | 1 | Horizontal sync from the timing controller, active high |
| vSyncIn | input | 1 | Vertical sync from the timing controller, active high |
| chrEn | input | 1 | Character-clock enable, one system-clock strobe per character period |
| irqAck | input | 1 | Interrupt acknowledge / counter clear, active high |
| monSync | output | 1 | Shaped monitor sync with frame-start inversion |
| irqN | output | 1 | Raster interrupt request, active low |

## Verification
The sync window advances on the same clock edge that samples chrEn with hSyncIn high. The bench therefore applies one whole character period of four clocks per step and reads monSync at the falling clock edge after that period, when the count of enabled edges is known exactly.

The line count and the interrupt counter both change on the first clock after hSyncIn is sampled low. irqN is therefore read once a full low step has passed. The realignment clear lands one clock after the vertical sync edge, well inside the three-step vertical sync sequence. An acknowledge is seen on irqN one clock after it is sampled, so irqN is read at the end of the step that carried it.

// File: rtl/sync_irq_pkg.sv
package sync_irq_pkg;

  // Strobes handed from the control half to the datapath half.
  typedef struct packed {
    logic lineEnd;   // horizontal pulse has just ended
    logic chrTick;   // character-clock enable this cycle
    logic hsHigh;    // horizontal sync currently high
    logic intClr;    // clear the interrupt counter
    logic ackClr;    // drop the pending interrupt
  } strobeT;

endpackage

// File: rtl/sync_irq_ctrl.sv
module sync_irq_ctrl
  import sync_irq_pkg::*;
#(
  parameter int LINE_STOP   = 28,
  parameter int EARLY_LINES = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hSyncIn,
  input  logic   vSyncIn,
  input  logic   chrEn,
  input  logic   irqAck,
  output strobeT strb,
  output logic   lineEarly
);

  localparam int LINE_W = $clog2(LINE_STOP + 1);

  logic              hsD;
  logic              vsD;
  logic [LINE_W-1:0] lineCnt;
  logic              earlyQ;
  logic              hsFall;
  logic              vsRise;
  logic              earlyNow;
  logic              realign;

  assign hsFall   = hsD & ~hSyncIn;
  assign vsRise   = vSyncIn & ~vsD;
  assign earlyNow = lineCnt < LINE_W'(EARLY_LINES);
  assign realign  = earlyNow & ~earlyQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsD <= 1'b0;
      vsD <= 1'b0;
    end else begin
      hsD <= hSyncIn;
      vsD <= vSyncIn;
    end
  end

  // Lines since the last frame start, saturating at the stop value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lineCnt <= LINE_W'(LINE_STOP);
    end else if (vsRise) begin
      lineCnt <= '0;
    end else if (hsFall && lineCnt != LINE_W'(LINE_STOP)) begin
      lineCnt <= lineCnt + LINE_W'(1);
    end
  end

  // Previous early-line state, used to find the drop back below the limit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) earlyQ <= 1'b0;
    else        earlyQ <= earlyNow;
  end

  always_comb begin
    strb.lineEnd = hsFall;
    strb.chrTick = chrEn;
    strb.hsHigh  = hSyncIn;
    strb.intClr  = realign | irqAck;
    strb.ackClr  = irqAck;
  end

  assign lineEarly = earlyNow;

endmodule

// File: rtl/sync_irq_dp.sv
module sync_irq_dp
  import sync_irq_pkg::*;
#(
  parameter int WIN_DELAY  = 4,
  parameter int WIN_LEN    = 4,
  parameter int IRQ_PERIOD = 52
) (
  input  logic   clk,
  input  logic   rst_n,
  input  strobeT strb,
  input  logic   lineEarly,
  output logic   monSync,
  output logic   irqN
);

  localparam int SH_MAX = WIN_DELAY + WIN_LEN;
  localparam int SH_W   = $clog2(SH_MAX + 1);
  localparam int INT_W  = $clog2(IRQ_PERIOD);

  logic [SH_W-1:0]  phase;
  logic             shLock;
  logic [INT_W-1:0] intCnt;
  logic             irqFlag;
  logic             wrap;

  // Pulse shaper: held clear while horizontal sync is low, locks when done.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      shLock <= 1'b0;
    end else if (!strb.hsHigh) begin
      phase  <= '0;
      shLock <= 1'b0;
    end else if (strb.chrTick && !shLock) begin
      if (phase == SH_W'(SH_MAX - 1)) begin
        phase  <= '0;
        shLock <= 1'b1;
      end else begin
        phase <= phase + SH_W'(1);
      end
    end
  end

  assign monSync = (phase >= SH_W'(WIN_DELAY)) ^ lineEarly;

  // Interrupt line counter and pending flag.
  assign wrap = strb.lineEnd && (intCnt == INT_W'(IRQ_PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intCnt <= '0;
    end else if (strb.intClr) begin
      intCnt <= '0;
    end else if (strb.lineEnd) begin
      intCnt <= wrap ? '0 : intCnt + INT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           irqFlag <= 1'b0;
    else if (strb.ackClr) irqFlag <= 1'b0;
    else if (wrap)        irqFlag <= 1'b1;
  end

  assign irqN = ~irqFlag;

endmodule

// File: rtl/sync_irq_gen.sv
module sync_irq_gen
  import sync_irq_pkg::*;
#(
  parameter int LINE_STOP   = 28,
  parameter int EARLY_LINES = 4,
  parameter int WIN_DELAY   = 4,
  parameter int WIN_LEN     = 4,
  parameter int IRQ_PERIOD  = 52
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hSyncIn,
  input  logic vSyncIn,
  input  logic chrEn,
  input  logic irqAck,
  output logic monSync,
  output logic irqN
);

  strobeT strb;
  logic   lineEarly;

  sync_irq_ctrl #(
    .LINE_STOP  (LINE_STOP),
    .EARLY_LINES(EARLY_LINES)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .hSyncIn  (hSyncIn),
    .vSyncIn  (vSyncIn),
    .chrEn    (chrEn),
    .irqAck   (irqAck),
    .strb     (strb),
    .lineEarly(lineEarly)
  );

  sync_irq_dp #(
    .WIN_DELAY (WIN_DELAY),
    .WIN_LEN   (WIN_LEN),
    .IRQ_PERIOD(IRQ_PERIOD)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .lineEarly(lineEarly),
    .monSync  (monSync),
    .irqN     (irqN)
  );

endmodule

// File: rtl/sync_irq_chk.sv
module sync_irq_chk (
  input logic clk,
  input logic rst_n,
  input logic hSyncIn,
  input logic vSyncIn,
  input logic chrEn,
  input logic irqAck,
  input logic monSync,
  input logic irqN,
  input logic lineEarly
);

  // R8: an acknowledge leaves no pending interrupt on the next clock.
  a_r8_ack_releases: assert property (@(posedge clk) disable iff (!rst_n)
    irqAck |=> irqN);

  // R7: the interrupt only appears right after the end of a horizontal pulse.
  a_r7_irq_at_line_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irqN) |-> ($past(hSyncIn, 2) && !$past(hSyncIn)));

  // R3: with horizontal sync low, the output sits at the line's idle level.
  a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!hSyncIn) |-> (monSync == lineEarly));

  // R9: no character tick, no pulse end, no frame edge -> output holds.
  a_r9_output_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (hSyncIn && !chrEn && $stable(vSyncIn)) |=> $stable(monSync));

  // R1: outputs are at their rest values whenever reset is applied.
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_values: assert (irqN == 1'b1);
    end
  end

endmodule

bind sync_irq_gen sync_irq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hSyncIn  (hSyncIn),
  .vSyncIn  (vSyncIn),
  .chrEn    (chrEn),
  .irqAck   (irqAck),
  .monSync  (monSync),
  .irqN     (irqN),
  .lineEarly(lineEarly)
);

// File: tb/sync_irq_gen_tb.sv
`timescale 1ns/1ps
module sync_irq_gen_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hSyncIn = 1'b0;
  logic vSyncIn = 1'b0;
  logic chrEn = 1'b0;
  logic irqAck = 1'b0;
  logic monSync;
  logic irqN;

  int total = 0;
  int bad = 0;
  int bLc = 28;     // lines since frame start, from R4
  int bInt = 0;     // interrupt counter, from R6/R7/R8
  logic bIrq = 1'b0;

  always #2.5 clk = ~clk;

  sync_irq_gen u_dut (
    .clk(clk), .rst_n(rst_n), .hSyncIn(hSyncIn), .vSyncIn(vSyncIn),
    .chrEn(chrEn), .irqAck(irqAck), .monSync(monSync), .irqN(irqN)
  );

  // {vertical sync before this line, expected inversion}
  localparam logic [1:0] LINE_TAB [0:10] = '{
    2'b11, 2'b01, 2'b01, 2'b01, 2'b00, 2'b00,
    2'b11, 2'b01, 2'b01, 2'b01, 2'b00
  };

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // One character period: four clocks, chrEn on the first.
  task automatic step(input logic h, input logic v, input logic ack);
    hSyncIn = h; vSyncIn = v; chrEn = 1'b1; irqAck = ack;
    @(negedge clk);
    chrEn = 1'b0; irqAck = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic doVsync();
    if (bLc >= 4) bInt = 0;          // R6 realignment
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    bLc = 0;
  endtask

  task automatic ackNow();
    step(1'b0, 1'b0, 1'b1);
    bInt = 0; bIrq = 1'b0;
    chk("R8 ack clears pending", irqN, 1'b1);
  endtask

  task automatic runLine(input logic expInv, input logic ackAtEnd);
    for (int n = 1; n <= 12; n++) begin
      step(1'b1, 1'b0, 1'b0);
      if (n >= 4 && n <= 7) chk("R2 window active", monSync, ~expInv);
      else                  chk("R2 window idle", monSync, expInv);
    end
    step(1'b0, 1'b0, ackAtEnd);
    if (bLc < 28) bLc++;
    if (ackAtEnd) begin
      bInt = 0; bIrq = 1'b0;
    end else if (bInt == 51) begin
      bInt = 0; bIrq = 1'b1;
    end else begin
      bInt++;
    end
    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 1'b0);
    chk("R3 idle level while hsync low", monSync, (bLc < 4));
    chk("R7 interrupt state", irqN, ~bIrq);
  endtask

  initial begin
    #750000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 monSync at reset", monSync, 1'b0);
    chk("R1 irqN at reset", irqN, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 before any vertical sync: counter at stop, no inversion.
    runLine(1'b0, 1'b0);

    // Table walk: R2/R5 over two frames.
    for (int i = 0; i <= 10; i++) begin
      if (LINE_TAB[i][1]) doVsync();
      chk("R5 model agrees with table", logic'(bLc < 4), LINE_TAB[i][0]);
      runLine(LINE_TAB[i][0], 1'b0);
    end

    // R4/R5: counter saturates at 28, no wrap back to inverted lines.
    doVsync();
    for (int i = 0; i < 36; i++) runLine(logic'(i < 4), 1'b0);
    chk("R4 still not inverted after 36 lines", monSync, 1'b0);

    // R6: vertical sync re-phases the interrupt counter (it held 36).
    doVsync();
    for (int i = 1; i <= 52; i++) begin
      runLine(logic'(bLc < 4), 1'b0);
      if (i == 16) chk("R6 no interrupt at old phase", irqN, 1'b1);
      if (i == 51) chk("R6 no interrupt before 52 lines", irqN, 1'b1);
    end
    chk("R6 interrupt on 52nd line after realign", irqN, 1'b0);

    // R8: acknowledge clears the counter partway through.
    ackNow();
    for (int i = 0; i < 20; i++) runLine(logic'(bLc < 4), 1'b0);
    ackNow();
    for (int i = 1; i <= 52; i++) runLine(logic'(bLc < 4), 1'b0);
    chk("R7 interrupt 52 lines after clear", irqN, 1'b0);
    ackNow();

    // R8: acknowledge on the wrapping pulse end wins over the set.
    for (int i = 1; i <= 51; i++) runLine(logic'(bLc < 4), 1'b0);
    runLine(logic'(bLc < 4), 1'b1);
    chk("R8 ack beats wrap", irqN, 1'b1);
    for (int i = 1; i <= 52; i++) runLine(logic'(bLc < 4), 1'b0);
    chk("R7 next interrupt after 52 more lines", irqN, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule